// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits on the bus side of a processor front end. It fetches code bytes ahead of the decode stage and keeps up to six of them in a byte-wide first-in, first-out queue. The fetch address is formed from a 16-bit code segment value and a 16-bit fetch pointer. Memory is reached through a simple request/ready port with a 16-bit data bus. A fetch reads a whole aligned word when the pointer is even and room allows, and reads a single byte when the pointer is odd, so that the next fetch is aligned again.

The decode stage takes one byte per handshake from a valid/ready output. A taken branch or other control transfer raises the flush input with a new segment and pointer. The queue then empties at once and fetching restarts from the new location. A pop and a fill may happen in the same cycle.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is held and right after it, the queue is empty (`empty_o`=1, `full_o`=0, `byte_valid_o`=0). Segment is 0xFFFF and pointer is 0x0000, so the first request is a word fetch at 0xFFFF0.
- R2: The fetch address is (segment × 16 + pointer), truncated to 20 bits.
- R3: With an even pointer and at least two free slots, a word request is made (`mem_word_o`=1). On acceptance, `mem_rdata_i[7:0]` enters the queue first and `mem_rdata_i[15:8]` second.
- R4: With an odd pointer and at least one free slot, a byte request is made (`mem_word_o`=0). The byte is taken from the odd lane `mem_rdata_i[15:8]`.
- R5: With an even pointer and only one free slot, or with the queue full, no request is made.
- R6: A request not yet accepted (`mem_ready_i`=0) stays raised with the same address and kind in the next cycle, unless a flush occurs.
- R7: The pointer advances by the number of bytes accepted (2 or 1) and wraps within 16 bits.
- R8: Bytes leave in fetch order, one per cycle in which `byte_valid_o` and `byte_ready_i` are both high. An untaken head byte stays valid and unchanged.
- R9: `empty_o` is high exactly when no byte is held. `full_o` is high exactly when six bytes are held.
- R10: In a flush cycle, `mem_req_o` and `byte_valid_o` are low, so no response or pop is taken. In the next cycle the queue is empty and fetching restarts from the new segment and pointer.
- R11: A pop and an accepted fetch in the same cycle both take effect, and the byte stream stays continuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Control transfer: empty queue, load segment and pointer |
| flush_seg_i | input | 16 | New code segment value |
| flush_ptr_i | input | 16 | New fetch pointer |
| mem_req_o | output | 1 | Fetch request |
| mem_addr_o | output | 20 | Physical fetch address |
| mem_word_o | output | 1 | 1 = word fetch, 0 = byte fetch |
| mem_ready_i | input | 1 | Memory accepts request; data valid this cycle |
| mem_rdata_i | input | 16 | Memory data, even byte in bits 7:0 |
| byte_valid_o | output | 1 | Head byte valid |
| byte_o | output | 8 | Head byte |
| byte_ready_i | input | 1 | Consumer takes head byte |
| empty_o | output | 1 | Queue holds no byte |
| full_o | output | 1 | Queue holds six bytes |

## Verification
Requests, addresses and head-byte outputs are combinational from registered state, so they are due in the same cycle as the state that causes them. Anything caused by an accepted fetch, a pop or a flush is due one clock edge later. The bench changes inputs just after a rising edge and samples on the falling edge, so each value is read in the cycle it is due. Counts such as "three word fetches fill the queue" are checked only after enough edges have passed for every registered step.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int SEG_W   = 16;
    localparam int PTR_W   = 16;
    localparam int PHYS_W  = 20;
    localparam int SHIFT   = 4;
    localparam int BYTE_W  = 8;
    localparam int BUS_W   = 2 * BYTE_W;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [PHYS_W-1:0] phys_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pfq_addr.sv
module pfq_addr
    import pfq_pkg::*;
(
    input  seg_t  seg_i,
    input  ptr_t  ptr_i,
    output phys_t phys_o
);
    always_comb begin
        phys_o = (PHYS_W'(seg_i) << SHIFT) + PHYS_W'(ptr_i);
    end
endmodule

// File: rtl/pfq_byte_fifo.sv
module pfq_byte_fifo
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [1:0]       push_n_i,
    input  byte_t            push_b0_i,
    input  byte_t            push_b1_i,
    input  logic             pop_i,
    output byte_t            head_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [CNT_W-1:0]             cnt;
    } fifo_s;

    fifo_s fifo_d, fifo_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        fifo_d = fifo_q;
        base   = fifo_q.cnt;
        if (pop_i) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                fifo_d.mem[i] = fifo_q.mem[i+1];
            end
            fifo_d.mem[DEPTH-1] = '0;
            base = fifo_q.cnt - CNT_W'(1);
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (push_n_i != 2'd0 && CNT_W'(i) == base) begin
                fifo_d.mem[i] = push_b0_i;
            end
            if (push_n_i == 2'd2 && CNT_W'(i) == base + CNT_W'(1)) begin
                fifo_d.mem[i] = push_b1_i;
            end
        end
        fifo_d.cnt = base + CNT_W'(push_n_i);
        if (clear_i) begin
            fifo_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    assign head_o  = fifo_q.mem[0];
    assign count_o = fifo_q.cnt;
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int   DEPTH     = 6,
    parameter logic [15:0] RESET_SEG = 16'hFFFF,
    parameter logic [15:0] RESET_PTR = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush_i,
    input  logic [15:0] flush_seg_i,
    input  logic [15:0] flush_ptr_i,
    output logic        mem_req_o,
    output logic [19:0] mem_addr_o,
    output logic        mem_word_o,
    input  logic        mem_ready_i,
    input  logic [15:0] mem_rdata_i,
    output logic        byte_valid_o,
    output logic [7:0]  byte_o,
    input  logic        byte_ready_i,
    output logic        empty_o,
    output logic        full_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        seg_t seg;
        ptr_t ptr;
    } fetch_s;

    fetch_s fetch_d, fetch_q;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] free_slots;
    logic             want_word;
    logic             want_byte;
    logic             accept;
    logic             pop;
    logic [1:0]       push_n;
    byte_t            push_b0;
    byte_t            push_b1;

    pfq_addr u_addr (
        .seg_i  (fetch_q.seg),
        .ptr_i  (fetch_q.ptr),
        .phys_o (mem_addr_o)
    );

    pfq_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (flush_i),
        .push_n_i  (push_n),
        .push_b0_i (push_b0),
        .push_b1_i (push_b1),
        .pop_i     (pop),
        .head_o    (byte_o),
        .count_o   (count)
    );

    always_comb begin
        free_slots   = CNT_W'(DEPTH) - count;
        want_word    = !fetch_q.ptr[0] && (free_slots >= CNT_W'(2));
        want_byte    = fetch_q.ptr[0] && (free_slots >= CNT_W'(1));
        mem_req_o    = (want_word || want_byte) && !flush_i;
        mem_word_o   = want_word;
        accept       = mem_req_o && mem_ready_i;
        push_n       = accept ? (want_word ? 2'd2 : 2'd1) : 2'd0;
        push_b0      = want_word ? mem_rdata_i[7:0] : mem_rdata_i[15:8];
        push_b1      = mem_rdata_i[15:8];
        empty_o      = (count == '0);
        full_o       = (count == CNT_W'(DEPTH));
        byte_valid_o = !empty_o && !flush_i;
        pop          = byte_valid_o && byte_ready_i;

        fetch_d      = fetch_q;
        fetch_d.ptr  = fetch_q.ptr + PTR_W'(push_n);
        if (flush_i) begin
            fetch_d.seg = flush_seg_i;
            fetch_d.ptr = flush_ptr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_q.seg <= RESET_SEG;
            fetch_q.ptr <= RESET_PTR;
        end else begin
            fetch_q <= fetch_d;
        end
    end
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_i,
    input logic        mem_req_o,
    input logic [19:0] mem_addr_o,
    input logic        mem_word_o,
    input logic        mem_ready_i,
    input logic        byte_valid_o,
    input logic [7:0]  byte_o,
    input logic        byte_ready_i,
    input logic        empty_o,
    input logic        full_o
);
    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_word_o |-> !mem_addr_o[0]);

    assert_odd_is_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_addr_o[0] |-> !mem_word_o);

    assert_no_req_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !mem_req_o);

    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i && !flush_i |=>
            flush_i || (mem_req_o && $stable(mem_addr_o) && $stable(mem_word_o)));

    assert_head_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o && !byte_ready_i && !flush_i |=>
            flush_i || (byte_valid_o && $stable(byte_o)));

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));

    assert_empty_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> !byte_valid_o);

    assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !mem_req_o && !byte_valid_o);

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);
endmodule

bind prefetch_queue pfq_checker u_pfq_checker (.*);

// File: tb/prefetch_queue_bench.sv
module prefetch_queue_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [15:0] flush_seg_i = '0;
    logic [15:0] flush_ptr_i = '0;
    logic        mem_req_o;
    logic [19:0] mem_addr_o;
    logic        mem_word_o;
    logic        mem_ready_i;
    logic [15:0] mem_rdata_i;
    logic        byte_valid_o;
    logic [7:0]  byte_o;
    logic        byte_ready_i = 1'b0;
    logic        empty_o;
    logic        full_o;
    logic        mem_en = 1'b0;

    int nchk = 0, nfail = 0, cyc = 0;
    int nacc = 0, nword = 0, nbyte = 0;
    logic first_word = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prefetch_queue u_prefetch_queue (.*);

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]};
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] p);
        return ({4'h0, s} << 4) + {4'h0, p};
    endfunction

    always_comb begin
        logic [19:0] al;
        al          = {mem_addr_o[19:1], 1'b0};
        mem_ready_i = mem_req_o && mem_en;
        mem_rdata_i = {mb(al + 20'd1), mb(al)};
    end

    always @(negedge clk) begin
        if (rst_n && mem_req_o && mem_ready_i) begin
            if (nacc == 0) first_word = mem_word_o;
            nacc++;
            if (mem_word_o) nword++; else nbyte++;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_flush(input logic [15:0] s, input logic [15:0] p);
        flush_i = 1'b1; flush_seg_i = s; flush_ptr_i = p;
        @(negedge clk);
        check("R10 req low in flush", mem_req_o, 1'b0);
        check("R10 valid low in flush", byte_valid_o, 1'b0);
        step(1);
        flush_i = 1'b0;
        nacc = 0; nword = 0; nbyte = 0;
        @(negedge clk);
        check("R10 empty after flush", empty_o, 1'b1);
        step(0);
        @(posedge clk); #1;
    endtask

    task automatic pop_one(input logic [7:0] exp, input string req);
        bit got = 0;
        byte_ready_i = 1'b1;
        for (int t = 0; t < 50 && !got; t++) begin
            @(negedge clk);
            if (byte_valid_o) begin
                check(req, byte_o, exp);
                got = 1;
            end
            @(posedge clk); #1;
        end
        byte_ready_i = 1'b0;
        if (!got) begin
            nchk++; nfail++;
            $display("FAIL %s: actual no byte expected %h", req, exp);
        end
    endtask

    task automatic pop_stream(input logic [15:0] s, input logic [15:0] p, input int from, input int n, input string req);
        for (int k = from; k < from + n; k++) begin
            pop_one(mb(phys(s, p + 16'(k))), req);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 empty in reset", empty_o, 1'b1);
        check("R1 not full in reset", full_o, 1'b0);
        check("R1 no valid in reset", byte_valid_o, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first addr", mem_addr_o, 20'hFFFF0);
        check("R1 first is word", mem_word_o, 1'b1);
        check("R1 first req", mem_req_o, 1'b1);
        @(posedge clk); #1;
    endtask

    task automatic t_even_fill();
        mem_en = 1'b1;
        do_flush(16'h1234, 16'h0100);
        step(5);
        @(negedge clk);
        check("R9 full", full_o, 1'b1);
        check("R5 no req when full", mem_req_o, 1'b0);
        check("R3 three words fill", nword, 3);
        check("R3 no byte fetch", nbyte, 0);
        check("R8 head before pop", byte_o, mb(phys(16'h1234, 16'h0100)));
        @(negedge clk);
        check("R8 head held", byte_o, mb(phys(16'h1234, 16'h0100)));
        @(posedge clk); #1;
        pop_stream(16'h1234, 16'h0100, 0, 14, "R11 stream even");
    endtask

    task automatic t_odd();
        mem_en = 1'b1;
        do_flush(16'h2000, 16'h0101);
        step(6);
        @(negedge clk);
        check("R4 first is byte", first_word, 1'b0);
        check("R4 one byte fetch", nbyte, 1);
        check("R3 two words after", nword, 2);
        check("R5 one slot no req", mem_req_o, 1'b0);
        check("R9 not full", full_o, 1'b0);
        check("R9 not empty", empty_o, 1'b0);
        @(posedge clk); #1;
        pop_one(mb(phys(16'h2000, 16'h0101)), "R4 odd lane byte");
        step(2);
        @(negedge clk);
        check("R9 refilled full", full_o, 1'b1);
        @(posedge clk); #1;
        pop_stream(16'h2000, 16'h0101, 1, 15, "R7 stream odd");
    endtask

    task automatic t_wrap();
        mem_en = 1'b0;
        do_flush(16'hF000, 16'hFFFE);
        @(negedge clk);
        check("R2 addr FFFFE", mem_addr_o, 20'hFFFFE);
        @(posedge clk); #1;
        mem_en = 1'b1;
        pop_stream(16'hF000, 16'hFFFE, 0, 8, "R7 ptr wrap");
        mem_en = 1'b0;
        do_flush(16'hFFFF, 16'h0010);
        @(negedge clk);
        check("R2 20-bit truncation", mem_addr_o, 20'h00000);
        @(posedge clk); #1;
        do_flush(16'h0040, 16'hFFFF);
        @(negedge clk);
        check("R2 addr 103FF", mem_addr_o, 20'h103FF);
        check("R4 byte at odd", mem_word_o, 1'b0);
        @(posedge clk); #1;
        mem_en = 1'b1;
        step(1);
        @(negedge clk);
        check("R7 wrap to offset 0", mem_addr_o, 20'h00400);
        @(posedge clk); #1;
        pop_stream(16'h0040, 16'hFFFF, 0, 5, "R7 odd wrap stream");
    endtask

    task automatic t_stall_flush();
        logic [19:0] a0;
        mem_en = 1'b0;
        do_flush(16'h3000, 16'h0006);
        @(negedge clk);
        a0 = mem_addr_o;
        check("R2 stall addr", a0, 20'h30006);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            @(negedge clk);
            check("R6 req held", mem_req_o, 1'b1);
            check("R6 addr stable", mem_addr_o, a0);
            check("R6 nothing queued", empty_o, 1'b1);
        end
        @(posedge clk); #1;
        mem_en = 1'b1;
        step(2);
        do_flush(16'h5000, 16'h0021);
        pop_stream(16'h5000, 16'h0021, 0, 6, "R10 new stream");
    endtask

    initial begin
        t_reset();
        t_even_fill();
        t_odd();
        t_wrap();
        t_stall_flush();
        summary();
        $finish;
    end
endmodule